// File: doc/BRIEF.md
# Eight-Port Memory Front End with Address Decode and Controller Arbitration

This block stands between eight independent requesters and a word-addressed store. The store is split between two internal controllers. For every request the block decides whether this memory answers. It then picks the controller that serves the request, picks one winner per controller when several ports compete, and steps each controller through a fixed busy period. The two controllers run side by side, so requests that land on different controllers overlap in time.

Each port has a 2-bit mode: 22-bit addressing, 18-bit addressing (the upper four bits are read as zero), or off. The memory occupies a window of 64K-word blocks that starts at a switch-set block number and spans 1, 2 or 4 blocks. One global flag turns on two-way interleave. Interleave exchanges the controller-select bit with the least significant address bit, so even and odd words land on different controllers. Each stored word carries a parity bit. It is computed on writes and checked on reads. The storage is a small behavioural array per controller, indexed by the low address bits that remain after controller selection.

Top module: `mport_mem_front`

## Requirements
- R1: Port p's mode is `cfg_mode[2p+1:2p]`: 2'b10 selects 22-bit addressing, 2'b01 selects 18-bit addressing, and 2'b00 or 2'b11 switches the port off. An off port never receives `ack`.
- R2: In 18-bit mode, address bits 21:18 are treated as zero before any comparison. A 22-bit port presenting the same address is decoded with those bits intact.
- R3: A request hits only when its block number (address bits 21:16), minus `cfg_base`, lies in the range 0 to `cfg_banks`-1. All other requests are never acknowledged.
- R4: `cfg_banks` values 1, 2 and 4 are legal. Any other value drives `cfg_err` high and suppresses every acknowledge.
- R5: Without interleave, address bit 15 selects the controller. Requests to different controllers are acknowledged in the same cycle, and at most one port per controller is acknowledged in a cycle.
- R6: With `cfg_ilv` high, address bits 15 and 0 are exchanged before decoding. Even addresses then go to controller 0 and odd addresses to controller 1.
- R7: A granted request sees `ack` high for exactly one cycle, in the cycle after the grant edge. A granted write is stored at that grant, and a later read of the same address returns it.
- R8: A granted read returns `rvalid` as a one-cycle pulse exactly ACCESS_CYC cycles after its `ack` cycle, with the stored word on that port's `rdata` slice.
- R9: Each stored word keeps a parity bit equal to the XOR of its 36 data bits. `perr` is raised only together with `rvalid`, and only when the data and the stored bit disagree.
- R10: A controller accepts a new request no sooner than CYCLE_CYC cycles after its previous grant. Contending requests to one controller are therefore acknowledged exactly CYCLE_CYC cycles apart.
- R11: Contending ports on one controller are served in round-robin order, searching upward from the port granted last, with wrap-around.
- R12: A port holds `req` until it sees `ack`. `ack` only follows a cycle in which `req` was high, and no acknowledge or read pulse is present after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 16 | Two mode bits per port |
| cfg_base | input | 6 | First 64K-word block number of this memory |
| cfg_banks | input | 3 | Number of 64K-word blocks (1, 2 or 4) |
| cfg_ilv | input | 1 | Two-way interleave enable, global |
| req | input | 8 | Request per port |
| we | input | 8 | Write (1) or read (0) per port |
| addr | input | 176 | 22-bit word address per port, port p at [22p+21:22p] |
| wdata | input | 288 | 36-bit write data per port, port p at [36p+35:36p] |
| ack | output | 8 | One-cycle grant acknowledge per port |
| rvalid | output | 8 | One-cycle read data valid per port |
| rdata | output | 288 | 36-bit read data per port |
| perr | output | 8 | Parity mismatch on the returned word, per port |
| cfg_err | output | 1 | Illegal bank count |

## Verification
The bench uses the defaults ACCESS_CYC = 5, CYCLE_CYC = 8 and ARR_AW = 6. The gap between access time and cycle time is therefore wide enough to tell a late read pulse from an early regrant. The 64-word array per controller is small enough to pick test addresses that never alias, yet it still spans bits on both sides of the interleave swap. With these values, three contending ports need 16 cycles to drain, which is short enough to check the full round-robin rotation and the exact CYCLE_CYC gaps within a compact run.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

    localparam int NPORT    = 8;
    localparam int NCTRL    = 2;
    localparam int ADDR_W   = 22;
    localparam int NARROW_W = 18;
    localparam int DATA_W   = 36;
    localparam int BANK_AW  = 16;
    localparam int CSEL_BIT = 15;
    localparam int BLK_W    = ADDR_W - BANK_AW;
    localparam int PW       = $clog2(NPORT);
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_OFF_LO = 2'b00,
        PM_NARROW = 2'b01,
        PM_WIDE   = 2'b10,
        PM_OFF_HI = 2'b11
    } pmode_e;

    typedef struct packed {
        logic hit;
        logic csel;
    } dec_t;

    function automatic logic banks_legal(input logic [2:0] n);
        return (n == 3'd1) || (n == 3'd2) || (n == 3'd4);
    endfunction

    function automatic logic word_parity(input logic [DATA_W-1:0] d);
        return ^d;
    endfunction

endpackage

// File: rtl/mpm_port_dec.sv
module mpm_port_dec
    import mpm_pkg::*;
#(
    parameter int ARR_AW = 6
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [BLK_W-1:0]  base,
    input  logic [2:0]        banks,
    input  logic              ilv,
    input  logic              cfg_ok,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [ARR_AW-1:0] idx
);

    pmode_e            m;
    logic [ADDR_W-1:0] a;
    logic [BLK_W-1:0]  blk;
    logic [BLK_W-1:0]  rel;
    logic              en;
    logic              inr;
    logic              unused_mid;

    always_comb begin
        m = pmode_e'(mode);
        a = addr;
        if (m == PM_NARROW) begin
            a[ADDR_W-1:NARROW_W] = '0;
        end
        en  = (m == PM_NARROW) || (m == PM_WIDE);
        blk = a[ADDR_W-1:BANK_AW];
        rel = blk - base;
        inr = (blk >= base) && (rel < BLK_W'(banks));
        dec.hit  = en && cfg_ok && inr;
        if (ilv) begin
            dec.csel = a[0];
            idx      = {a[ARR_AW-1:1], a[CSEL_BIT]};
        end else begin
            dec.csel = a[CSEL_BIT];
            idx      = a[ARR_AW-1:0];
        end
    end

    assign unused_mid = ^a[CSEL_BIT-1:ARR_AW];

endmodule

// File: rtl/mpm_rr_arb.sv
module mpm_rr_arb #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 adv,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gid
);

    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic          found;
    int            k;

    always_comb begin
        gnt   = '0;
        gid   = '0;
        found = 1'b0;
        k     = 0;
        for (int i = 1; i <= N; i++) begin
            k = (int'(ptr) + i) % N;
            if (!found && req[k]) begin
                found  = 1'b1;
                gnt[k] = 1'b1;
                gid    = IW'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= IW'(N - 1);
        end else if (adv) begin
            ptr <= gid;
        end
    end

endmodule

// File: rtl/mpm_ctrl.sv
module mpm_ctrl
    import mpm_pkg::*;
#(
    parameter int ACCESS_CYC = 5,
    parameter int CYCLE_CYC  = 8,
    parameter int ARR_AW     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PW-1:0]     sport,
    input  logic              swe,
    input  logic [ARR_AW-1:0] sidx,
    input  logic [DATA_W-1:0] swdata,
    output logic              idle,
    output logic              rv,
    output logic [PW-1:0]     rport,
    output logic [DATA_W-1:0] rdata,
    output logic              rperr
);

    localparam int DEPTH = 1 << ARR_AW;
    localparam int CW    = $clog2(CYCLE_CYC + 1);

    logic [DATA_W:0]   mem [DEPTH];
    logic [CW-1:0]     cnt;
    logic [PW-1:0]     h_port;
    logic              h_we;
    logic [ARR_AW-1:0] h_idx;
    logic [DATA_W:0]   rd_word;

    assign idle    = (cnt == '0) || (cnt == CW'(CYCLE_CYC));
    assign rd_word = mem[h_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            h_port <= '0;
            h_we   <= 1'b0;
            h_idx  <= '0;
            rv     <= 1'b0;
            rport  <= '0;
            rdata  <= '0;
            rperr  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            rv    <= 1'b0;
            rperr <= 1'b0;
            if (cnt == CW'(ACCESS_CYC) && !h_we) begin
                rv    <= 1'b1;
                rport <= h_port;
                rdata <= rd_word[DATA_W-1:0];
                rperr <= word_parity(rd_word[DATA_W-1:0]) != rd_word[DATA_W];
            end
            if (start) begin
                cnt    <= CW'(1);
                h_port <= sport;
                h_we   <= swe;
                h_idx  <= sidx;
                if (swe) begin
                    mem[sidx] <= {word_parity(swdata), swdata};
                end
            end else if (cnt == CW'(CYCLE_CYC)) begin
                cnt <= '0;
            end else if (cnt != '0) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/mport_mem_front.sv
module mport_mem_front
    import mpm_pkg::*;
#(
    parameter int ACCESS_CYC = 5,
    parameter int CYCLE_CYC  = 8,
    parameter int ARR_AW     = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORT*MODE_W-1:0]  cfg_mode,
    input  logic [BLK_W-1:0]         cfg_base,
    input  logic [2:0]               cfg_banks,
    input  logic                     cfg_ilv,
    input  logic [NPORT-1:0]         req,
    input  logic [NPORT-1:0]         we,
    input  logic [NPORT*ADDR_W-1:0]  addr,
    input  logic [NPORT*DATA_W-1:0]  wdata,
    output logic [NPORT-1:0]         ack,
    output logic [NPORT-1:0]         rvalid,
    output logic [NPORT*DATA_W-1:0]  rdata,
    output logic [NPORT-1:0]         perr,
    output logic                     cfg_err
);

    dec_t              dec  [NPORT];
    logic [ARR_AW-1:0] didx [NPORT];
    logic              cfg_ok;

    logic [NPORT-1:0]  creq   [NCTRL];
    logic [NPORT-1:0]  gnt    [NCTRL];
    logic [PW-1:0]     gid    [NCTRL];
    logic              cidle  [NCTRL];
    logic              cstart [NCTRL];
    logic              c_rv   [NCTRL];
    logic [PW-1:0]     c_port [NCTRL];
    logic [DATA_W-1:0] c_data [NCTRL];
    logic              c_perr [NCTRL];

    logic [NPORT-1:0]  ack_q;
    logic [NPORT-1:0]  ack_nxt;

    assign cfg_ok  = banks_legal(cfg_banks);
    assign cfg_err = !cfg_ok;
    assign ack     = ack_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mpm_port_dec #(.ARR_AW(ARR_AW)) u_dec (
            .mode   (cfg_mode[MODE_W*p +: MODE_W]),
            .base   (cfg_base),
            .banks  (cfg_banks),
            .ilv    (cfg_ilv),
            .cfg_ok (cfg_ok),
            .addr   (addr[ADDR_W*p +: ADDR_W]),
            .dec    (dec[p]),
            .idx    (didx[p])
        );
    end

    for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
        for (genvar p = 0; p < NPORT; p++) begin : g_req
            assign creq[c][p] = req[p] && dec[p].hit && !ack_q[p]
                                && (dec[p].csel == 1'(c));
        end

        assign cstart[c] = cidle[c] && (|creq[c]);

        mpm_rr_arb #(.N(NPORT)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (creq[c]),
            .adv (cstart[c]),
            .gnt (gnt[c]),
            .gid (gid[c])
        );

        mpm_ctrl #(
            .ACCESS_CYC (ACCESS_CYC),
            .CYCLE_CYC  (CYCLE_CYC),
            .ARR_AW     (ARR_AW)
        ) u_ctrl (
            .clk    (clk),
            .rst    (rst),
            .start  (cstart[c]),
            .sport  (gid[c]),
            .swe    (we[gid[c]]),
            .sidx   (didx[gid[c]]),
            .swdata (wdata[DATA_W*gid[c] +: DATA_W]),
            .idle   (cidle[c]),
            .rv     (c_rv[c]),
            .rport  (c_port[c]),
            .rdata  (c_data[c]),
            .rperr  (c_perr[c])
        );
    end

    always_comb begin
        ack_nxt = '0;
        for (int c = 0; c < NCTRL; c++) begin
            if (cstart[c]) begin
                ack_nxt = ack_nxt | gnt[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= '0;
        end else begin
            ack_q <= ack_nxt;
        end
    end

    always_comb begin
        rvalid = '0;
        rdata  = '0;
        perr   = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int c = 0; c < NCTRL; c++) begin
                if (c_rv[c] && c_port[c] == PW'(p)) begin
                    rvalid[p]                  = 1'b1;
                    rdata[DATA_W*p +: DATA_W]  = c_data[c];
                    perr[p]                    = c_perr[c];
                end
            end
        end
    end

endmodule

// File: rtl/mpm_checker.sv
module mpm_checker
    import mpm_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [NPORT*MODE_W-1:0] cfg_mode,
    input logic                    cfg_err,
    input logic [NPORT-1:0]        req,
    input logic [NPORT-1:0]        ack,
    input logic [NPORT-1:0]        rvalid,
    input logic [NPORT-1:0]        perr
);

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        AST_OFF_PORT_SILENT: assert property (@(posedge clk) disable iff (rst)
            ack[p] |-> ($past(cfg_mode[MODE_W*p +: MODE_W]) == 2'b01 ||
                        $past(cfg_mode[MODE_W*p +: MODE_W]) == 2'b10)); // R1

        AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
            ack[p] |-> $past(req[p])); // R12

        AST_PERR_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
            perr[p] |-> rvalid[p]); // R9
    end

    AST_CFG_ERR_MUTE: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_err) |-> (ack == '0)); // R4

    AST_ONE_PER_CTRL: assert property (@(posedge clk) disable iff (rst)
        $countones(ack) <= NCTRL); // R5

endmodule

bind mport_mem_front mpm_checker u_mpm_checker (
    .clk      (clk),
    .rst      (rst),
    .cfg_mode (cfg_mode),
    .cfg_err  (cfg_err),
    .req      (req),
    .ack      (ack),
    .rvalid   (rvalid),
    .perr     (perr)
);

// File: tb/tb_mport_mem_front.sv
`timescale 1ns/1ps
module tb_mport_mem_front;
    import mpm_pkg::*;

    localparam int ACC = 5;
    localparam int CYC = 8;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [NPORT*MODE_W-1:0] cfg_mode;
    logic [BLK_W-1:0]        cfg_base = '0;
    logic [2:0]              cfg_banks = 3'd1;
    logic                    cfg_ilv = 1'b0;
    logic [NPORT-1:0]        req;
    logic [NPORT-1:0]        we;
    logic [NPORT*ADDR_W-1:0] addr;
    logic [NPORT*DATA_W-1:0] wdata;
    logic [NPORT-1:0]        ack;
    logic [NPORT-1:0]        rvalid;
    logic [NPORT*DATA_W-1:0] rdata;
    logic [NPORT-1:0]        perr;
    logic                    cfg_err;

    logic [1:0]        mode_b [NPORT];
    logic              req_b  [NPORT];
    logic              we_b   [NPORT];
    logic [ADDR_W-1:0] addr_b [NPORT];
    logic [DATA_W-1:0] wd_b   [NPORT];

    typedef struct {
        logic [DATA_W-1:0] d;
        int                c;
    } exp_t;
    exp_t sq [NPORT][$];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            cfg_mode[MODE_W*p +: MODE_W] = mode_b[p];
            req[p]                       = req_b[p];
            we[p]                        = we_b[p];
            addr[ADDR_W*p +: ADDR_W]     = addr_b[p];
            wdata[DATA_W*p +: DATA_W]    = wd_b[p];
        end
    end

    mport_mem_front #(.ACCESS_CYC(ACC), .CYCLE_CYC(CYC), .ARR_AW(6)) dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_base(cfg_base),
        .cfg_banks(cfg_banks), .cfg_ilv(cfg_ilv), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .ack(ack), .rvalid(rvalid),
        .rdata(rdata), .perr(perr), .cfg_err(cfg_err)
    );

    function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Scoreboard monitor: pops expected read returns
    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NPORT; p++) begin
                if (rvalid[p]) begin
                    if (sq[p].size() == 0) begin
                        chk(1'b0, "R8 unexpected rvalid", 64'(p), 64'hff);
                    end else begin
                        exp_t e;
                        e = sq[p].pop_front();
                        chk(rdata[DATA_W*p +: DATA_W] == e.d, "R7 read data",
                            64'(rdata[DATA_W*p +: DATA_W]), 64'(e.d));
                        chk(cyc == e.c, "R8 read latency", 64'(cyc), 64'(e.c));
                        chk(perr[p] == 1'b0, "R9 parity clean", 64'(perr[p]), 64'd0);
                    end
                end
            end
        end
    end

    // Driver: issue one request, wait for ack, push expected read
    task automatic xfer(input int p, input bit w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input int maxw,
                        output bit got, output int ackc);
        exp_t e;
        @(negedge clk);
        req_b[p] = 1'b1; we_b[p] = w; addr_b[p] = a; wd_b[p] = d;
        got = 1'b0; ackc = -1;
        for (int i = 0; i < maxw && !got; i++) begin
            @(negedge clk);
            if (ack[p]) begin
                got = 1'b1;
                ackc = cyc;
            end
        end
        req_b[p] = 1'b0;
        if (got && !w) begin
            e.d = d;
            e.c = ackc + ACC;
            sq[p].push_back(e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12 watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        bit g0, g1, g2;
        int c0, c1, c2;
        int ord [3];
        for (int p = 0; p < NPORT; p++) begin
            mode_b[p] = 2'b10; req_b[p] = 1'b0; we_b[p] = 1'b0;
            addr_b[p] = '0; wd_b[p] = '0;
        end
        cfg_base = 6'd2; cfg_banks = 3'd2;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(ack == '0, "R12 reset ack", 64'(ack), 64'd0);
        chk(rvalid == '0, "R12 reset rvalid", 64'(rvalid), 64'd0);
        chk(cfg_err == 1'b0, "R4 legal banks", 64'(cfg_err), 64'd0);

        // R7/R8: write then read, inside the window
        xfer(0, 1, 22'h20005, 36'h123456789, 20, g0, c0);
        chk(g0, "R7 write ack", 64'(g0), 64'd1);
        xfer(3, 0, 22'h20005, 36'h123456789, 20, g0, c0);
        chk(g0, "R7 read ack", 64'(g0), 64'd1);
        xfer(1, 1, 22'h3FFFF, 36'hABCDEF012, 20, g0, c0);
        chk(g0, "R3 top of window", 64'(g0), 64'd1);
        xfer(2, 0, 22'h3FFFF, 36'hABCDEF012, 20, g0, c0);

        // R3: just outside both ends
        xfer(4, 0, 22'h40000, 36'h0, 20, g0, c0);
        chk(!g0, "R3 above window", 64'(g0), 64'd0);
        xfer(4, 0, 22'h1FFFF, 36'h0, 20, g0, c0);
        chk(!g0, "R3 below window", 64'(g0), 64'd0);

        // R5: different controllers overlap; R10: same controller spaced
        idle(10);
        fork
            xfer(0, 1, 22'h20010, 36'h111, 40, g0, c0);
            xfer(1, 1, 22'h28010, 36'h222, 40, g1, c1);
        join
        chk(g0 && g1 && c0 == c1, "R5 parallel controllers", 64'(c1), 64'(c0));
        idle(10);
        fork
            xfer(2, 1, 22'h20020, 36'h333, 40, g0, c0);
            xfer(3, 1, 22'h20030, 36'h444, 40, g1, c1);
        join
        chk(g0 && g1 && (c0 > c1 ? c0 - c1 : c1 - c0) == CYC, "R10 busy spacing",
            64'(c0 > c1 ? c0 - c1 : c1 - c0), 64'(CYC));

        // R6: interleave, even/odd split
        cfg_ilv = 1'b1;
        idle(10);
        fork
            xfer(4, 1, 22'h20040, 36'h555, 40, g0, c0);
            xfer(5, 1, 22'h20041, 36'h666, 40, g1, c1);
        join
        chk(g0 && g1 && c0 == c1, "R6 even odd parallel", 64'(c1), 64'(c0));
        idle(10);
        fork
            xfer(6, 1, 22'h20042, 36'h777, 40, g0, c0);
            xfer(7, 1, 22'h20044, 36'h888, 40, g1, c1);
        join
        chk(g0 && g1 && (c0 > c1 ? c0 - c1 : c1 - c0) == CYC, "R6 two evens serialise",
            64'(c0 > c1 ? c0 - c1 : c1 - c0), 64'(CYC));
        xfer(0, 0, 22'h20041, 36'h666, 40, g0, c0);
        xfer(1, 0, 22'h20044, 36'h888, 40, g0, c0);
        idle(12);
        cfg_ilv = 1'b0;

        // R2: narrow port drops upper bits
        mode_b[1] = 2'b01; cfg_base = 6'd0; cfg_banks = 3'd1;
        xfer(1, 1, 22'h3C0011, 36'h9999, 20, g0, c0);
        chk(g0, "R2 narrow port hits", 64'(g0), 64'd1);
        xfer(2, 1, 22'h3C0011, 36'h0, 20, g0, c0);
        chk(!g0, "R2 wide port misses", 64'(g0), 64'd0);
        xfer(0, 0, 22'h000011, 36'h9999, 20, g0, c0);
        mode_b[1] = 2'b10;

        // R1: ports switched off
        mode_b[4] = 2'b00; mode_b[5] = 2'b11;
        xfer(4, 0, 22'h000012, 36'h0, 20, g0, c0);
        chk(!g0, "R1 mode 00 silent", 64'(g0), 64'd0);
        xfer(5, 0, 22'h000012, 36'h0, 20, g0, c0);
        chk(!g0, "R1 mode 11 silent", 64'(g0), 64'd0);
        mode_b[4] = 2'b10; mode_b[5] = 2'b10;

        // R4: illegal and largest bank counts
        cfg_banks = 3'd3;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R4 cfg_err on 3", 64'(cfg_err), 64'd1);
        xfer(0, 0, 22'h000013, 36'h0, 20, g0, c0);
        chk(!g0, "R4 no ack on error", 64'(g0), 64'd0);
        cfg_banks = 3'd4;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R4 four banks legal", 64'(cfg_err), 64'd0);
        xfer(0, 1, 22'h30013, 36'hFEDCBA987, 20, g0, c0);
        chk(g0, "R3 fourth block hit", 64'(g0), 64'd1);
        xfer(6, 0, 22'h30013, 36'hFEDCBA987, 20, g0, c0);
        xfer(0, 0, 22'h40013, 36'h0, 20, g0, c0);
        chk(!g0, "R3 past four blocks", 64'(g0), 64'd0);

        // R11: three contenders on controller 0
        idle(10);
        fork
            xfer(2, 1, 22'h00021, 36'hA1, 60, g0, c0);
            xfer(4, 1, 22'h00022, 36'hA2, 60, g1, c1);
            xfer(6, 1, 22'h00023, 36'hA3, 60, g2, c2);
        join
        chk(g0 && g1 && g2, "R11 all served", 64'({g0, g1, g2}), 64'h7);
        begin
            int cs [3];
            int ps [3];
            cs[0] = c0; cs[1] = c1; cs[2] = c2;
            ps[0] = 2;  ps[1] = 4;  ps[2] = 6;
            for (int r = 0; r < 3; r++) begin
                int mn;
                mn = 0;
                for (int j = 1; j < 3; j++) if (cs[j] < cs[mn]) mn = j;
                ord[r] = ps[mn];
                cs[mn] = 32'h7fffffff;
            end
        end
        chk(((ord[1] - ord[0] + 8) % 8) < ((ord[2] - ord[0] + 8) % 8),
            "R11 rotation order", 64'(ord[1]), 64'(ord[2]));
        {c0, c1, c2} = {c0, c1, c2};

        idle(20);
        for (int p = 0; p < NPORT; p++) begin
            chk(sq[p].size() == 0, "R8 all reads returned", 64'(sq[p].size()), 64'd0);
        end
        finish_run();
    end

endmodule